// File: doc/BRIEF.md
# Programmable Color Bar Pattern Generator

This block is a test-pattern source. Once enabled, it repeats a frame of vertical color bars. The frame comes out as a byte stream ready for a CSI-2 style packet transmitter. Each frame is framed by single-cycle start and end strobes. Every active line is framed by line-start and line-end strobes, and its payload bytes are qualified by a valid flag. A data identifier travels with the frame so the downstream packetizer can build headers.

All settings live in a small internal register bank behind an indirect window. The host writes an index through one host address and then reads or writes the selected register through the other. The generator works from a shadow copy of the settings. That copy is taken only when a frame begins, so the host may rewrite the bank at any time without tearing a frame in progress. Clearing the enable lets the current frame run to its end, and the generator then goes quiet.

Top module: `cbar_pgen`

## Requirements
- R1: Host address 0 reads and writes an 8-bit index. Host address 1 reads and writes the internal register that the index selects. Internal registers 0x01..0x0F are stored, and indices 0x00 and 0x10..0xFF read as 0 and ignore writes. Reset values: index 0, reg 0x02 = 0x33, reg 0x03 = 0x2C, reg 0x01 = 0x00.
- R2: Bit 0 of reg 0x01 enables the generator. While it is 0 from reset, no strobe and no valid byte appear. Setting it starts a frame within a few cycles.
- R3: A frame lasts E lines of P cycles each. P is the 16-bit line period {reg 0x0C, reg 0x0D}. E is the larger of the total line count {reg 0x0A, reg 0x0B} and back porch (reg 0x0E) + active lines {reg 0x08, reg 0x09} + front porch (reg 0x0F). The frame-start strobe is high in the first cycle of line 0. The frame-end strobe is high in the last cycle of line E-1. While enabled, the next frame-start follows in the very next cycle.
- R4: Exactly the lines numbered back porch through back porch + active - 1 are active lines. Every other line carries no strobe and no valid byte apart from the frame-start and frame-end strobes.
- R5: In an active line, line-start is high at tick 0. Valid bytes appear at ticks 1..S, where S is the 16-bit line size {reg 0x04, reg 0x05}. Line-end is high at tick S+1. This assumes P >= S+2 and S >= 1.
- R6: Payload byte p (0-based) of a line belongs to bar b = min(p / B, N-1). B is the bar size {reg 0x06, reg 0x07}, and N = 2^reg0x02[5:4], giving 1, 2, 4 or 8 bars. The byte value is (b+1)*0x11.
- R7: The data identifier output equals reg 0x03 as it stood when the current frame began.
- R8: Register writes made during a frame do not change that frame. They take effect from the next frame-start.
- R9: Clearing the enable mid-frame lets the current frame finish with its frame-end strobe. After that, no further frame-start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Host address: 0 index, 1 data |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the selected address |
| fs_o | output | 1 | Frame-start strobe |
| fe_o | output | 1 | Frame-end strobe |
| ls_o | output | 1 | Line-start strobe |
| le_o | output | 1 | Line-end strobe |
| dt_o | output | 8 | Data identifier of the current frame |
| pix_valid_o | output | 1 | Payload byte valid |
| pix_data_o | output | 8 | Payload byte |

## Verification
The hardest case to reach is a host write that lands in the middle of a running frame. Two things must hold there: the frame must not change, and the new value must appear exactly at the next frame-start. A second hard case is a disable that arrives partway through a frame. The stimulus forks a register writer alongside the frame monitor and times it to strike mid-frame, first with a data identifier change and then with a disable. Randomized small geometries also cover bar saturation, where line size over bar size exceeds the bar count, and total line counts shorter than porches plus active lines.

// File: rtl/cbar_pgen_pkg.sv
package cbar_pgen_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BAR_W  = 3;
  localparam int unsigned NREG   = 16;

  localparam logic [7:0] IDX_CTL   = 8'h01;
  localparam logic [7:0] IDX_BARS  = 8'h02;
  localparam logic [7:0] IDX_DT    = 8'h03;
  localparam logic [7:0] IDX_LSZ_H = 8'h04;
  localparam logic [7:0] IDX_LSZ_L = 8'h05;
  localparam logic [7:0] IDX_BSZ_H = 8'h06;
  localparam logic [7:0] IDX_BSZ_L = 8'h07;
  localparam logic [7:0] IDX_ACT_H = 8'h08;
  localparam logic [7:0] IDX_ACT_L = 8'h09;
  localparam logic [7:0] IDX_TOT_H = 8'h0A;
  localparam logic [7:0] IDX_TOT_L = 8'h0B;
  localparam logic [7:0] IDX_PD_H  = 8'h0C;
  localparam logic [7:0] IDX_PD_L  = 8'h0D;
  localparam logic [7:0] IDX_VBP   = 8'h0E;
  localparam logic [7:0] IDX_VFP   = 8'h0F;

  typedef struct packed {
    logic [1:0]       nbar_code;
    logic [7:0]       dt;
    logic [CNT_W-1:0] line_sz;
    logic [CNT_W-1:0] bar_sz;
    logic [CNT_W-1:0] act_lines;
    logic [CNT_W-1:0] tot_lines;
    logic [CNT_W-1:0] line_pd;
    logic [7:0]       vbp;
    logic [7:0]       vfp;
  } pgen_cfg_t;

  function automatic logic [7:0] reg_rst_val(input int unsigned idx);
    case (idx)
      2:  return 8'h33;
      3:  return 8'h2C;
      4:  return 8'h0B;
      5:  return 8'h40;
      6:  return 8'h01;
      7:  return 8'h68;
      8:  return 8'h04;
      9:  return 8'h38;
      10: return 8'h04;
      11: return 8'h65;
      12: return 8'h0B;
      13: return 8'h93;
      14: return 8'h21;
      15: return 8'h0A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bar_color(input logic [BAR_W-1:0] b);
    logic [7:0] n;
    n = 8'(b) + 8'd1;
    return n * 8'h11;
  endfunction
endpackage

// File: rtl/cbar_pgen_regs.sv
module cbar_pgen_regs
  import cbar_pgen_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic      sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic      en_o,
  output pgen_cfg_t cfg_o
);
  localparam int unsigned IW = $clog2(NREG);

  logic [7:0] idx_q;
  logic [7:0] regs_q [NREG];
  logic       hit;

  assign hit = (idx_q < 8'(NREG)) && (idx_q != 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= 8'h00;
    else if (we_i && !sel_i)    idx_q <= wdata_i;
  end

  assign regs_q[0] = 8'h00;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= reg_rst_val(i);
      else if (we_i && sel_i && hit && (idx_q[IW-1:0] == IW'(i)))
        regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    if (!sel_i)   rdata_o = idx_q;
    else if (hit) rdata_o = regs_q[idx_q[IW-1:0]];
    else          rdata_o = 8'h00;
  end

  assign en_o            = regs_q[IDX_CTL[IW-1:0]][0];
  assign cfg_o.nbar_code = regs_q[IDX_BARS[IW-1:0]][5:4];
  assign cfg_o.dt        = regs_q[IDX_DT[IW-1:0]];
  assign cfg_o.line_sz   = {regs_q[IDX_LSZ_H[IW-1:0]], regs_q[IDX_LSZ_L[IW-1:0]]};
  assign cfg_o.bar_sz    = {regs_q[IDX_BSZ_H[IW-1:0]], regs_q[IDX_BSZ_L[IW-1:0]]};
  assign cfg_o.act_lines = {regs_q[IDX_ACT_H[IW-1:0]], regs_q[IDX_ACT_L[IW-1:0]]};
  assign cfg_o.tot_lines = {regs_q[IDX_TOT_H[IW-1:0]], regs_q[IDX_TOT_L[IW-1:0]]};
  assign cfg_o.line_pd   = {regs_q[IDX_PD_H[IW-1:0]], regs_q[IDX_PD_L[IW-1:0]]};
  assign cfg_o.vbp       = regs_q[IDX_VBP[IW-1:0]];
  assign cfg_o.vfp       = regs_q[IDX_VFP[IW-1:0]];
endmodule

// File: rtl/cbar_pgen_timing.sv
module cbar_pgen_timing
  import cbar_pgen_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  pgen_cfg_t cfg_i,
  output pgen_cfg_t shd_o,
  output logic      fs_o,
  output logic      fe_o,
  output logic      ls_o,
  output logic      le_o,
  output logic      pay_o
);
  localparam int unsigned LW = CNT_W + 2;

  pgen_cfg_t        shd_q;
  logic             run_q;
  logic [CNT_W-1:0] tick_q;
  logic [LW-1:0]    line_q;
  logic [LW-1:0]    act_end, min_tot, eff_tot;
  logic [CNT_W:0]   le_tick;
  logic             last_tick, last_line, active;

  assign act_end   = LW'(shd_q.vbp) + LW'(shd_q.act_lines);
  assign min_tot   = act_end + LW'(shd_q.vfp);
  // porches plus active lines set a floor under the total
  assign eff_tot   = (LW'(shd_q.tot_lines) >= min_tot) ? LW'(shd_q.tot_lines) : min_tot;
  assign last_tick = tick_q == (shd_q.line_pd - CNT_W'(1));
  assign last_line = line_q == (eff_tot - LW'(1));
  assign active    = run_q && (line_q >= LW'(shd_q.vbp)) && (line_q < act_end);
  assign le_tick   = {1'b0, shd_q.line_sz} + (CNT_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      line_q <= '0;
      shd_q  <= '0;
    end else if (!run_q) begin
      tick_q <= '0;
      line_q <= '0;
      if (en_i) begin
        run_q <= 1'b1;
        shd_q <= cfg_i;
      end
    end else if (last_tick) begin
      tick_q <= '0;
      if (last_line) begin
        line_q <= '0;
        if (en_i) shd_q <= cfg_i;
        else      run_q <= 1'b0;
      end else begin
        line_q <= line_q + LW'(1);
      end
    end else begin
      tick_q <= tick_q + CNT_W'(1);
    end
  end

  assign shd_o = shd_q;
  assign fs_o  = run_q && (line_q == '0) && (tick_q == '0);
  assign fe_o  = run_q && last_line && last_tick;
  assign ls_o  = active && (tick_q == '0);
  assign pay_o = active && (tick_q != '0) && (tick_q <= shd_q.line_sz);
  assign le_o  = active && ({1'b0, tick_q} == le_tick);
endmodule

// File: rtl/cbar_pgen_bars.sv
module cbar_pgen_bars
  import cbar_pgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ls_i,
  input  logic             pay_i,
  input  logic [1:0]       nbar_code_i,
  input  logic [CNT_W-1:0] bar_sz_i,
  output logic [7:0]       data_o
);
  logic [BAR_W-1:0] bar_q, max_bar;
  logic [CNT_W-1:0] cnt_q;

  assign max_bar = BAR_W'((32'd1 << nbar_code_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q <= '0;
      cnt_q <= '0;
    end else if (ls_i) begin
      bar_q <= '0;
      cnt_q <= '0;
    end else if (pay_i) begin
      if (cnt_q == bar_sz_i - CNT_W'(1)) begin
        cnt_q <= '0;
        if (bar_q < max_bar) bar_q <= bar_q + BAR_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign data_o = bar_color(bar_q);
endmodule

// File: rtl/cbar_pgen.sv
module cbar_pgen
  import cbar_pgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_we_i,
  input  logic       host_sel_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  output logic       fs_o,
  output logic       fe_o,
  output logic       ls_o,
  output logic       le_o,
  output logic [7:0] dt_o,
  output logic       pix_valid_o,
  output logic [7:0] pix_data_o
);
  pgen_cfg_t  live_cfg, shd_cfg;
  logic       en;
  logic       pay;
  logic [7:0] color;

  cbar_pgen_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_we_i),
    .sel_i   (host_sel_i),
    .wdata_i (host_wdata_i),
    .rdata_o (host_rdata_o),
    .en_o    (en),
    .cfg_o   (live_cfg)
  );

  cbar_pgen_timing u_timing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .cfg_i  (live_cfg),
    .shd_o  (shd_cfg),
    .fs_o   (fs_o),
    .fe_o   (fe_o),
    .ls_o   (ls_o),
    .le_o   (le_o),
    .pay_o  (pay)
  );

  cbar_pgen_bars u_bars (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ls_i        (ls_o),
    .pay_i       (pay),
    .nbar_code_i (shd_cfg.nbar_code),
    .bar_sz_i    (shd_cfg.bar_sz),
    .data_o      (color)
  );

  assign dt_o        = shd_cfg.dt;
  assign pix_valid_o = pay;
  assign pix_data_o  = pay ? color : 8'h00;
endmodule

// File: rtl/cbar_pgen_chk.sv
module cbar_pgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fs_o,
  input logic       fe_o,
  input logic       ls_o,
  input logic       le_o,
  input logic [7:0] dt_o,
  input logic       pix_valid_o,
  input logic [7:0] pix_data_o
);
  AST_FS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |=> !fs_o); // R3
  AST_FE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_o |=> !fe_o); // R3
  AST_VALID_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (!ls_o && !le_o)); // R5
  AST_LE_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_o |-> $past(pix_valid_o)); // R5
  AST_BYTE_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_data_o[7:4] == pix_data_o[3:0] && pix_data_o != 8'h00)); // R6
  AST_DT_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dt_o) |-> fs_o); // R8
endmodule

bind cbar_pgen cbar_pgen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fs_o        (fs_o),
  .fe_o        (fe_o),
  .ls_o        (ls_o),
  .le_o        (le_o),
  .dt_o        (dt_o),
  .pix_valid_o (pix_valid_o),
  .pix_data_o  (pix_data_o)
);

// File: tb/cbar_pgen_tb_top.sv
module cbar_pgen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_we_i = 1'b0;
  logic       host_sel_i = 1'b0;
  logic [7:0] host_wdata_i = 8'h00;
  logic [7:0] host_rdata_o;
  logic       fs_o, fe_o, ls_o, le_o, pix_valid_o;
  logic [7:0] dt_o, pix_data_o;

  int total = 0;
  int bad = 0;

  int c_code, c_sz, c_bar, c_pd, c_vbp, c_act, c_vfp, c_tot;

  always #2 clk_i = ~clk_i;

  cbar_pgen dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_sel_i   (host_sel_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .fs_o         (fs_o),
    .fe_o         (fe_o),
    .ls_o         (ls_o),
    .le_o         (le_o),
    .dt_o         (dt_o),
    .pix_valid_o  (pix_valid_o),
    .pix_data_o   (pix_data_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_lines();
    int m;
    m = c_vbp + c_act + c_vfp;
    return (c_tot >= m) ? c_tot : m;
  endfunction

  function automatic int exp_byte(input int p);
    int b, nb;
    nb = 1 << c_code;
    b = p / c_bar;
    if (b > nb - 1) b = nb - 1;
    return ((b + 1) * 17) & 255;
  endfunction

  task automatic host_write(input bit sel, input logic [7:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_sel_i = sel; host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    host_write(1'b0, idx);
    host_write(1'b1, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    host_write(1'b0, idx);
    host_sel_i = 1'b1;
    #1 d = host_rdata_o;
  endtask

  task automatic load_cfg(input int dt);
    reg_write(8'h02, 8'(c_code << 4) | 8'h03);
    reg_write(8'h03, 8'(dt));
    reg_write(8'h04, 8'(c_sz >> 8));  reg_write(8'h05, 8'(c_sz));
    reg_write(8'h06, 8'(c_bar >> 8)); reg_write(8'h07, 8'(c_bar));
    reg_write(8'h08, 8'(c_act >> 8)); reg_write(8'h09, 8'(c_act));
    reg_write(8'h0A, 8'(c_tot >> 8)); reg_write(8'h0B, 8'(c_tot));
    reg_write(8'h0C, 8'(c_pd >> 8));  reg_write(8'h0D, 8'(c_pd));
    reg_write(8'h0E, 8'(c_vbp));
    reg_write(8'h0F, 8'(c_vfp));
  endtask

  // waits for frame-start at negedges, then compares every cycle of one frame
  task automatic check_frame(input int exp_dt, output int waited);
    int n, e_fs, e_fe, e_ls, e_le, e_val, e_dat, e_dt;
    bit shown;
    e_fs = 0; e_fe = 0; e_ls = 0; e_le = 0; e_val = 0; e_dat = 0; e_dt = 0;
    shown = 0;
    waited = 0;
    @(negedge clk_i);
    while (!fs_o && waited < 20000) begin
      waited++;
      @(negedge clk_i);
    end
    check(fs_o == 1'b1, "R2", "frame start seen", int'(fs_o), 1);
    n = eff_lines() * c_pd;
    for (int c = 0; c < n; c++) begin
      int l, t;
      bit act, x_ls, x_le, x_v;
      l = c / c_pd;
      t = c % c_pd;
      act = (l >= c_vbp) && (l < c_vbp + c_act);
      x_ls = act && (t == 0);
      x_le = act && (t == c_sz + 1);
      x_v  = act && (t >= 1) && (t <= c_sz);
      if (fs_o != (c == 0)) e_fs++;
      if (fe_o != (c == n - 1)) e_fe++;
      if (ls_o != x_ls) e_ls++;
      if (le_o != x_le) e_le++;
      if (pix_valid_o != x_v) e_val++;
      if (x_v && pix_valid_o && int'(pix_data_o) != exp_byte(t - 1)) begin
        e_dat++;
        if (!shown) begin
          shown = 1;
          $display("mismatch line %0d tick %0d data %0h exp %0h", l, t, pix_data_o, exp_byte(t - 1));
        end
      end
      if (int'(dt_o) != exp_dt) e_dt++;
      if (c != n - 1) @(negedge clk_i);
    end
    check(e_fs + e_fe == 0, "R3", "frame strobe errors", e_fs + e_fe, 0);
    check(e_ls == 0, "R4", "line-start errors", e_ls, 0);
    check(e_le + e_val == 0, "R5", "line-end/valid errors", e_le + e_val, 0);
    check(e_dat == 0, "R6", "bar byte errors", e_dat, 0);
    check(e_dt == 0, "R7", "data id errors", e_dt, 0);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int hits;
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (fs_o || fe_o || ls_o || le_o || pix_valid_o) hits++;
    end
    check(hits == 0, req, "activity while idle", hits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int w;
    int unsigned seed;
    seed = $urandom(32'd4242);

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10-style reset state folded into R1/R2
    #1 check(host_rdata_o == 8'h00, "R1", "reset index", int'(host_rdata_o), 0);
    expect_quiet(40, "R2");
    reg_read(8'h02, rd);
    check(rd == 8'h33, "R1", "reset bar reg", int'(rd), 'h33);
    reg_read(8'h03, rd);
    check(rd == 8'h2C, "R1", "reset dt reg", int'(rd), 'h2C);
    reg_write(8'h0E, 8'h5A);
    reg_read(8'h0E, rd);
    check(rd == 8'h5A, "R1", "readback", int'(rd), 'h5A);
    host_sel_i = 1'b0;
    #1 check(host_rdata_o == 8'h0E, "R1", "index readback", int'(host_rdata_o), 'h0E);
    reg_write(8'h00, 8'h77);
    reg_read(8'h00, rd);
    check(rd == 8'h00, "R1", "index 0 ignored", int'(rd), 0);
    reg_write(8'h10, 8'h55);
    reg_read(8'h10, rd);
    check(rd == 8'h00, "R1", "index 0x10 ignored", int'(rd), 0);
    expect_quiet(10, "R2");

    // directed: 8 bars saturating, porches, R8 mid-frame write
    c_code = 3; c_sz = 24; c_bar = 2; c_pd = 28;
    c_vbp = 1; c_act = 3; c_vfp = 1; c_tot = 6;
    load_cfg('h2C);
    reg_write(8'h01, 8'h01);
    fork
      check_frame('h2C, w);
      begin
        repeat (40) @(negedge clk_i);
        reg_write(8'h03, 8'h2B);
      end
    join
    check_frame('h2B, w);
    check(w == 0, "R8", "new dt frame back to back", w, 0);

    // R9: disable mid-frame
    fork
      check_frame('h2B, w);
      begin
        repeat (30) @(negedge clk_i);
        reg_write(8'h01, 8'h00);
      end
    join
    check(w == 0, "R3", "consecutive frame start", w, 0);
    expect_quiet(3 * c_pd, "R9");

    // random geometries
    for (int it = 0; it < 6; it++) begin
      int dt;
      c_code = int'($urandom_range(3, 0));
      c_sz   = int'($urandom_range(24, 1));
      c_bar  = int'($urandom_range(8, 1));
      c_pd   = c_sz + 2 + int'($urandom_range(6, 0));
      c_vbp  = int'($urandom_range(3, 0));
      c_act  = int'($urandom_range(4, 1));
      c_vfp  = int'($urandom_range(2, 0));
      c_tot  = int'($urandom_range(11, 1));
      dt     = int'($urandom_range(255, 0));
      load_cfg(dt);
      reg_write(8'h01, 8'h01);
      check_frame(dt, w);
      check_frame(dt, w);
      check(w == 0, "R3", "random back to back", w, 0);
      reg_write(8'h01, 8'h00);
      w = 0;
      while (!fe_o && w < 2000) begin
        @(negedge clk_i);
        w++;
      end
      check(fe_o == 1'b1, "R9", "frame ends after disable", int'(fe_o), 1);
      expect_quiet(2 * c_pd + 5, "R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule